// File: doc/BRIEF.md
# Halfword-Swapping DMA Address and Data Formatter

This block sits between a 16-bit peripheral of opposite byte order and the memory side of a DMA channel. Each peripheral request gives an offset, a byte length, a direction and a swap flag. The block turns the request into one or more memory burst commands and moves the 16-bit data beats through. In network mode, the burst address is the request offset ORed with a base value. When swapping is asked for, the low address bit and the low length bit are cleared, and the two bytes of every halfword are exchanged in both directions. Swapped writes are split into bursts of at most 64 bytes.

A second mode serves a storage-style channel. In this mode the burst address comes from an internal transfer pointer, and swap and base are not used. The pointer moves forward by the request length once the transfer finishes. Software can load the pointer through a load strobe. The data path has no storage, so back-pressure on the memory side reaches the peripheral in the same cycle.

Top module: `hsw_dma_path`

## Requirements
- R1: In network mode (chan_mode=0), the command address equals req_offset bitwise-ORed with base_addr, not their sum.
- R2: In network mode with req_swap=1, bit 0 of the command address and bit 0 of the total length are forced to 0.
- R3: While a swapped transfer runs, bits [15:8] and [7:0] of each beat are exchanged: in_data to mem_wdata on writes, and mem_rdata to out_data on reads.
- R4: A swapped network write is issued as successive commands of CHUNK (64) bytes, with the last command taking the remainder. Each command address is the previous one plus the previous length. Reads and unswapped transfers use one command.
- R5: An unswapped network request issues one command with the merged address and the unchanged length (odd values kept), and data passes unchanged. The beat count is the length divided by 2, rounded up.
- R6: In pointer mode (chan_mode=1), the command address is ptr_value and the length is req_len, with no swap. After done, ptr_value has advanced by req_len.
- R7: When ptr_load is high in the same cycle as the pointer advance, the loaded value wins and the advance is dropped.
- R8: A request whose effective length is 0 issues no command, and done_o rises in the cycle after acceptance.
- R9: While mem_wready is low, in_ready is low, and a command held without mem_cmd_ready keeps its address and length. No beat is lost or repeated.
- R10: done_o is a one-cycle pulse in the cycle after the final beat is accepted. req_ready is high only while no transfer is active, and ptr_value is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_mode | input | 1 | 0 network mode, 1 pointer mode |
| base_addr | input | AW | Base merged by OR in network mode |
| ptr_load | input | 1 | Load strobe for the transfer pointer |
| ptr_load_val | input | AW | Value loaded into the pointer |
| ptr_value | output | AW | Current transfer pointer |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_offset | input | AW | Request offset |
| req_len | input | LW | Request length in bytes |
| req_write | input | 1 | 1 peripheral to memory, 0 memory to peripheral |
| req_swap | input | 1 | Swap bytes within halfwords |
| done_o | output | 1 | Transfer finished pulse |
| in_valid | input | 1 | Peripheral write beat valid |
| in_ready | output | 1 | Peripheral write beat taken |
| in_data | input | 16 | Peripheral write beat |
| out_valid | output | 1 | Read beat to peripheral valid |
| out_ready | input | 1 | Peripheral takes read beat |
| out_data | output | 16 | Read beat to peripheral |
| mem_cmd_valid | output | 1 | Burst command valid |
| mem_cmd_ready | input | 1 | Burst command taken |
| mem_cmd_addr | output | AW | Burst byte address |
| mem_cmd_len | output | LW | Burst length in bytes |
| mem_cmd_write | output | 1 | Burst direction |
| mem_wvalid | output | 1 | Write beat valid |
| mem_wready | input | 1 | Write beat taken |
| mem_wdata | output | 16 | Write beat to memory |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rready | output | 1 | Read beat taken |
| mem_rdata | input | 16 | Read beat from memory |

## Verification
Two pointer functions can land in the same cycle: the automatic advance at the end of a pointer-mode transfer, and a software load. The bench waits until done_o is visible, drives ptr_load during that cycle, and then expects the loaded value on ptr_value, not the loaded value plus the length and not the advanced old pointer. A following transfer confirms that the new command address uses the loaded pointer. A second overlap occurs when a burst's last beat and memory back-pressure fall together. The bench provokes it by toggling mem_wready and mem_cmd_ready, and judges it by beat count, data order and the timing of done_o.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  localparam int BEAT_W = 16;
  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_DATA, ST_DONE} hsw_state_e;
endpackage

// File: rtl/hsw_lane_swap.sv
module hsw_lane_swap #(
  parameter int LANES = 1
) (
  input  logic                en,
  input  logic [16*LANES-1:0] d,
  output logic [16*LANES-1:0] q
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign q[16*g +: 8]   = en ? d[16*g+8 +: 8] : d[16*g +: 8];
    assign q[16*g+8 +: 8] = en ? d[16*g +: 8]   : d[16*g+8 +: 8];
  end
endmodule

// File: rtl/hsw_ptr_reg.sv
module hsw_ptr_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  input  logic [AW-1:0] adv_amt,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (adv)  q <= q + adv_amt;
  end
endmodule

// File: rtl/hsw_seq.sv
module hsw_seq
  import hsw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LW    = 16,
  parameter int CHUNK = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_mode,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] ptr_q,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_offset,
  input  logic [LW-1:0] req_len,
  input  logic          req_write,
  input  logic          req_swap,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [AW-1:0] cmd_addr,
  output logic [LW-1:0] cmd_len,
  output logic          cmd_write,
  output logic          data_phase,
  input  logic          beat_fire,
  output logic          done,
  output logic          adv,
  output logic [AW-1:0] adv_amt,
  output logic          cur_swap,
  output logic          cur_write,
  output logic          cur_chunked
);
  localparam logic [LW-1:0] CHUNK_L = LW'(CHUNK);

  function automatic logic [AW-1:0] merge_addr(input logic [AW-1:0] off,
                                               input logic [AW-1:0] base,
                                               input logic sw);
    logic [AW-1:0] a;
    a = off | base;
    if (sw) a[0] = 1'b0;
    return a;
  endfunction

  function automatic logic [LW-1:0] eff_len(input logic [LW-1:0] len, input logic sw);
    logic [LW-1:0] l;
    l = len;
    if (sw) l[0] = 1'b0;
    return l;
  endfunction

  function automatic logic [LW-1:0] chunk_of(input logic [LW-1:0] rem, input logic ch);
    return (ch && rem > CHUNK_L) ? CHUNK_L : rem;
  endfunction

  function automatic logic [LW-1:0] beats_of(input logic [LW-1:0] len);
    logic [LW:0] t;
    t = {1'b0, len} + 1'b1;
    return t[LW:1];
  endfunction

  hsw_state_e    st;
  logic          mode_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] rem_q, tot_q, chunk_q, beats_q;
  logic [LW-1:0] acc_len, chunk_w;

  assign acc_len    = chan_mode ? req_len : eff_len(req_len, req_swap);
  assign chunk_w    = chunk_of(rem_q, cur_chunked);
  assign req_ready  = (st == ST_IDLE);
  assign cmd_valid  = (st == ST_CMD);
  assign cmd_addr   = addr_q;
  assign cmd_len    = chunk_w;
  assign cmd_write  = cur_write;
  assign data_phase = (st == ST_DATA);
  assign done       = (st == ST_DONE);
  assign adv        = done && mode_q;
  assign adv_amt    = AW'(tot_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      mode_q      <= 1'b0;
      cur_write   <= 1'b0;
      cur_swap    <= 1'b0;
      cur_chunked <= 1'b0;
      addr_q      <= '0;
      rem_q       <= '0;
      tot_q       <= '0;
      chunk_q     <= '0;
      beats_q     <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          mode_q      <= chan_mode;
          cur_write   <= req_write;
          cur_swap    <= !chan_mode && req_swap;
          cur_chunked <= !chan_mode && req_swap && req_write;
          addr_q      <= chan_mode ? ptr_q : merge_addr(req_offset, base_addr, req_swap);
          rem_q       <= acc_len;
          tot_q       <= req_len;
          st          <= (acc_len == '0) ? ST_DONE : ST_CMD;
        end
        ST_CMD: if (cmd_ready) begin
          chunk_q <= chunk_w;
          beats_q <= beats_of(chunk_w);
          st      <= ST_DATA;
        end
        ST_DATA: if (beat_fire) begin
          if (beats_q == LW'(1)) begin
            rem_q  <= rem_q - chunk_q;
            addr_q <= addr_q + AW'(chunk_q);
            st     <= (rem_q == chunk_q) ? ST_DONE : ST_CMD;
          end else begin
            beats_q <= beats_q - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hsw_dma_path.sv
module hsw_dma_path
  import hsw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LW    = 16,
  parameter int CHUNK = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_mode,
  input  logic [AW-1:0]     base_addr,
  input  logic              ptr_load,
  input  logic [AW-1:0]     ptr_load_val,
  output logic [AW-1:0]     ptr_value,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_offset,
  input  logic [LW-1:0]     req_len,
  input  logic              req_write,
  input  logic              req_swap,
  output logic              done_o,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BEAT_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BEAT_W-1:0] out_data,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ready,
  output logic [AW-1:0]     mem_cmd_addr,
  output logic [LW-1:0]     mem_cmd_len,
  output logic              mem_cmd_write,
  output logic              mem_wvalid,
  input  logic              mem_wready,
  output logic [BEAT_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  output logic              mem_rready,
  input  logic [BEAT_W-1:0] mem_rdata
);
  localparam int LANES = BEAT_W / 16;

  logic          data_phase, beat_fire, cur_swap, cur_write, cur_chunked;
  logic          ptr_adv;
  logic [AW-1:0] ptr_amt;

  hsw_ptr_reg #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(ptr_load_val),
    .adv(ptr_adv), .adv_amt(ptr_amt), .q(ptr_value)
  );

  hsw_seq #(.AW(AW), .LW(LW), .CHUNK(CHUNK)) u_seq (
    .clk(clk), .rst_n(rst_n), .chan_mode(chan_mode), .base_addr(base_addr),
    .ptr_q(ptr_value), .req_valid(req_valid), .req_ready(req_ready),
    .req_offset(req_offset), .req_len(req_len), .req_write(req_write),
    .req_swap(req_swap), .cmd_valid(mem_cmd_valid), .cmd_ready(mem_cmd_ready),
    .cmd_addr(mem_cmd_addr), .cmd_len(mem_cmd_len), .cmd_write(mem_cmd_write),
    .data_phase(data_phase), .beat_fire(beat_fire), .done(done_o),
    .adv(ptr_adv), .adv_amt(ptr_amt), .cur_swap(cur_swap),
    .cur_write(cur_write), .cur_chunked(cur_chunked)
  );

  assign mem_wvalid = data_phase && cur_write && in_valid;
  assign in_ready   = data_phase && cur_write && mem_wready;
  assign out_valid  = data_phase && !cur_write && mem_rvalid;
  assign mem_rready = data_phase && !cur_write && out_ready;
  assign beat_fire  = (mem_wvalid && mem_wready) || (mem_rvalid && mem_rready);

  hsw_lane_swap #(.LANES(LANES)) u_wswap (.en(cur_swap), .d(in_data),   .q(mem_wdata));
  hsw_lane_swap #(.LANES(LANES)) u_rswap (.en(cur_swap), .d(mem_rdata), .q(out_data));
endmodule

// File: rtl/hsw_dma_path_chk.sv
module hsw_dma_path_chk #(
  parameter int AW    = 32,
  parameter int LW    = 16,
  parameter int CHUNK = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [LW-1:0] req_len,
  input logic          done_o,
  input logic          in_ready,
  input logic [15:0]   in_data,
  input logic          mem_cmd_valid,
  input logic          mem_cmd_ready,
  input logic [AW-1:0] mem_cmd_addr,
  input logic [LW-1:0] mem_cmd_len,
  input logic          mem_wvalid,
  input logic          mem_wready,
  input logic [15:0]   mem_wdata,
  input logic          cur_swap,
  input logic          cur_chunked
);
  p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && cur_swap |-> !mem_cmd_addr[0] && !mem_cmd_len[0]);

  p_swap_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid && cur_swap |-> mem_wdata == {in_data[7:0], in_data[15:8]});

  p_chunk_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && cur_chunked |-> mem_cmd_len <= LW'(CHUNK) && mem_cmd_len != '0);

  p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_len == '0 |=> done_o);

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid && !mem_wready |-> !in_ready);

  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && !mem_cmd_ready |=> mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_len));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_cmd_valid && !mem_wvalid);
endmodule

bind hsw_dma_path hsw_dma_path_chk #(.AW(AW), .LW(LW), .CHUNK(CHUNK)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_len(req_len), .done_o(done_o), .in_ready(in_ready), .in_data(in_data),
  .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
  .mem_cmd_addr(mem_cmd_addr), .mem_cmd_len(mem_cmd_len),
  .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_wdata(mem_wdata),
  .cur_swap(cur_swap), .cur_chunked(cur_chunked)
);

// File: tb/tb_hsw_dma_path.sv
`timescale 1ns/1ps
module tb_hsw_dma_path;
  localparam int AW = 32;
  localparam int LW = 16;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic          chan_mode = 0, ptr_load = 0, req_valid = 0, req_write = 0, req_swap = 0;
  logic [AW-1:0] base_addr = 0, ptr_load_val = 0, req_offset = 0, ptr_value;
  logic [LW-1:0] req_len = 0;
  logic          req_ready, done_o, in_valid, in_ready, out_valid, out_ready;
  logic [15:0]   in_data, out_data, mem_wdata, mem_rdata;
  logic          mem_cmd_valid, mem_cmd_ready, mem_cmd_write, mem_wvalid, mem_wready;
  logic          mem_rvalid, mem_rready;
  logic [AW-1:0] mem_cmd_addr;
  logic [LW-1:0] mem_cmd_len;

  hsw_dma_path #(.AW(AW), .LW(LW), .CHUNK(64)) dut (.*);

  int vectors = 0, miscompares = 0;
  int cyc = 0, widx = 0, ridx = 0, nc = 0, nw = 0, nr = 0, ndone = 0;
  int done_cyc = 0, last_cyc = 0, acc_cyc = 0;
  bit bp_mode = 0;
  logic [AW-1:0] c_addr [0:15];
  logic [LW-1:0] c_len  [0:15];
  logic [15:0]   wd [0:127];
  logic [15:0]   rd [0:127];

  function automatic logic [15:0] wsrc(input int i);
    return {8'(i + 8'h11), 8'(i ^ 8'hA5)};
  endfunction
  function automatic logic [15:0] rsrc(input int i);
    return {8'(8'hC0 + i), 8'(i * 3)};
  endfunction
  function automatic logic [15:0] sw(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  assign in_valid  = 1'b1;
  assign out_ready = 1'b1;
  assign mem_rvalid = 1'b1;

  // environment: drive at falling edge, observe 1 ns later
  always begin
    @(negedge clk);
    in_data       = wsrc(widx);
    mem_rdata     = rsrc(ridx);
    mem_wready    = bp_mode ? (cyc % 3 != 0) : 1'b1;
    mem_cmd_ready = bp_mode ? (cyc % 2 != 0) : 1'b1;
    #1;
    if (mem_cmd_valid && mem_cmd_ready && nc < 16) begin
      c_addr[nc] = mem_cmd_addr; c_len[nc] = mem_cmd_len; nc++;
    end
    if (mem_wvalid && mem_wready) begin wd[nw & 127] = mem_wdata; nw++; last_cyc = cyc; end
    if (in_valid && in_ready) widx++;
    if (out_valid && out_ready) begin rd[nr & 127] = out_data; nr++; ridx++; last_cyc = cyc; end
    if (req_valid && req_ready) acc_cyc = cyc;
    if (done_o) begin ndone++; done_cyc = cyc; end
    cyc++;
  end

  initial begin
    #(5.0 * 150000);
    miscompares++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic start_req(input logic mode, input logic [AW-1:0] off, input logic [LW-1:0] len,
                           input logic wr, input logic swp);
    @(negedge clk);
    nc = 0; nw = 0; nr = 0; ndone = 0; widx = 0; ridx = 0;
    chan_mode = mode; req_offset = off; req_len = len; req_write = wr; req_swap = swp;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic run_req(input logic mode, input logic [AW-1:0] off, input logic [LW-1:0] len,
                         input logic wr, input logic swp);
    start_req(mode, off, len, wr, swp);
    for (int k = 0; k < 400 && ndone == 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R10 req_ready after reset", 32'(req_ready), 1);
    check("R10 cmd idle after reset", 32'(mem_cmd_valid), 0);
    check("R10 done low after reset", 32'(done_o), 0);
    check("R10 pointer after reset", ptr_value, 0);
  endtask

  task automatic t_or_merge;
    base_addr = 32'h0000_0105;
    run_req(0, 32'h13, 5, 1, 0);
    check("R1 one command", nc, 1);
    check("R1 OR-merged address", c_addr[0], 32'h117);
    check("R5 odd length kept", 32'(c_len[0]), 5);
    check("R5 beat count", nw, 3);
    for (int i = 0; i < 3; i++) check("R5 data unchanged", 32'(wd[i]), 32'(wsrc(i)));
    check("R10 single done", ndone, 1);
  endtask

  task automatic t_swap_read;
    base_addr = 32'h200;
    run_req(0, 32'h3, 7, 0, 1);
    check("R2 one read command", nc, 1);
    check("R2 address bit0 cleared", c_addr[0], 32'h202);
    check("R2 length bit0 cleared", 32'(c_len[0]), 6);
    check("R3 read beats", nr, 3);
    for (int i = 0; i < 3; i++) check("R3 read swapped", 32'(rd[i]), 32'(sw(rsrc(i))));
    check("R10 done after last read beat", done_cyc, last_cyc + 1);
  endtask

  task automatic t_chunk;
    base_addr = 32'h4000;
    run_req(0, 32'h101, 149, 1, 1);
    check("R4 chunk count", nc, 3);
    check("R4 chunk0 addr", c_addr[0], 32'h4100);
    check("R4 chunk0 len", 32'(c_len[0]), 64);
    check("R4 chunk1 addr", c_addr[1], 32'h4140);
    check("R4 chunk1 len", 32'(c_len[1]), 64);
    check("R4 chunk2 addr", c_addr[2], 32'h4180);
    check("R4 chunk2 len", 32'(c_len[2]), 20);
    check("R4 total beats", nw, 74);
    for (int i = 0; i < 74; i++) check("R3 write swapped", 32'(wd[i]), 32'(sw(wsrc(i))));
  endtask

  task automatic t_backpressure;
    base_addr = 32'h800;
    bp_mode = 1;
    run_req(0, 32'h0, 70, 1, 1);
    bp_mode = 0;
    check("R9 chunk count", nc, 2);
    check("R9 second chunk addr", c_addr[1], 32'h840);
    check("R9 second chunk len", 32'(c_len[1]), 6);
    check("R9 beats no loss", nw, 35);
    for (int i = 0; i < 35; i++) check("R9 beat order", 32'(wd[i]), 32'(sw(wsrc(i))));
    check("R10 done after last beat", done_cyc, last_cyc + 1);
    check("R10 single done", ndone, 1);
  endtask

  task automatic t_zero;
    run_req(0, 32'h40, 0, 1, 0);
    check("R8 no command len 0", nc, 0);
    check("R8 done one cycle after accept", done_cyc, acc_cyc + 1);
    check("R8 single done", ndone, 1);
    run_req(0, 32'h40, 1, 1, 1);
    check("R8 swapped len 1 no command", nc, 0);
    check("R8 swapped len 1 no beat", nw, 0);
    check("R8 swapped len 1 done timing", done_cyc, acc_cyc + 1);
  endtask

  task automatic load_ptr(input logic [AW-1:0] v);
    @(negedge clk); ptr_load = 1; ptr_load_val = v;
    @(negedge clk); ptr_load = 0;
  endtask

  task automatic t_pointer;
    base_addr = 32'hFFFF_0000;
    load_ptr(32'h1000);
    check("R6 pointer loaded", ptr_value, 32'h1000);
    run_req(1, 32'h55, 6, 1, 1);
    check("R6 command at pointer", c_addr[0], 32'h1000);
    check("R6 command length", 32'(c_len[0]), 6);
    check("R6 no swap in pointer mode", 32'(wd[0]), 32'(wsrc(0)));
    check("R6 pointer advanced", ptr_value, 32'h1006);
    run_req(1, 32'h0, 3, 0, 0);
    check("R6 read at pointer", c_addr[0], 32'h1006);
    check("R6 read beats", nr, 2);
    check("R6 pointer after read", ptr_value, 32'h1009);
  endtask

  task automatic t_collide;
    start_req(1, 32'h0, 4, 1, 0);
    for (int k = 0; k < 400 && !done_o; k++) @(negedge clk);
    check("R7 done reached", 32'(done_o), 1);
    ptr_load = 1; ptr_load_val = 32'h2000;
    @(negedge clk); ptr_load = 0;
    repeat (2) @(negedge clk);
    check("R7 load wins over advance", ptr_value, 32'h2000);
    run_req(1, 32'h0, 2, 1, 0);
    check("R7 next command at loaded pointer", c_addr[0], 32'h2000);
    check("R7 pointer after next", ptr_value, 32'h2002);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_or_merge();
    t_swap_read();
    t_chunk();
    t_backpressure();
    t_zero();
    t_pointer();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule